// File: doc/BRIEF.md
# Presence-Vector Coherence Directory Controller

This block is the home-side directory controller for one memory module in a cache-coherent multiprocessor. For each block of the module it keeps a presence vector, one bit per processor, and a dirty flag. A block with no presence bits set is uncached. A block with bits set and the flag clear is shared. A block with the flag set is exclusive, and its only presence bit names the owner. Read-miss and write-miss requests arrive from the network. The controller works out which coherence actions each request needs, issues them, waits for the answers, commits the new directory entry and replies to the requester.

A read of a dirty block recalls the line from its owner and downgrades the owner to shared. A write to a dirty block recalls the line and invalidates the owner. A write to a shared block sends one invalidation message, whose target mask lists every other sharer, and counts the acknowledgements. The grant is sent only after the last acknowledgement has arrived. The controller handles one transaction at a time. Any request that arrives while a transaction is open is refused with a NACK in the same cycle and leaves no trace. Memory data and DRAM timing stay outside the block. The `mem_upd` pulse marks the cycle in which recalled data is to be written back to the home memory.

The controller is built around one state machine. `ST_IDLE` accepts a request (*accept*). `ST_LOOKUP` reads the entry and selects one of three actions: *direct* to `ST_REPLY`, *recall* to `ST_RECALL`, or *invalidate* to `ST_INVAL`. `ST_RECALL` leaves on the owner's write-back (*writeback*). `ST_INVAL` leaves on the final acknowledgement (*last_ack*). `ST_REPLY` emits the grant and returns to idle (*done*). The directory entry is written on the transition into `ST_REPLY`.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every directory entry is uncached and every output is low. Every payload field (`nack_dst`, `rcl_dst`, `rcl_excl`, `inv_mask`, `rsp_dst`, `rsp_excl`, `mem_addr`) reads zero whenever its own valid signal is low.
- R2: A read to a block whose dirty flag is clear produces no recall and no invalidation. `rsp_valid` rises in the third cycle after acceptance, counting the accept cycle as the first. `rsp_dst` is the requester and `rsp_excl` is 0. The requester's presence bit is added to the entry.
- R3: A read to a dirty block whose owner is another processor asserts `rcl_valid` in the cycle after acceptance, with `rcl_dst` set to the owner and `rcl_excl` at 0 (downgrade). In the cycle where `wb_valid` is seen, `mem_upd` pulses with `mem_addr` set to the block. The reply follows one cycle later. The entry becomes shared, holding both the old owner and the requester.
- R4: A write to a clean block that has sharers other than the writer asserts `inv_valid` for one cycle, in the cycle after acceptance. Bit i of `inv_mask` is set exactly when processor i is a sharer other than the writer.
- R5: After an invalidation, `rsp_valid` rises in the cycle after the acknowledgement that brings the count up to the number of bits in `inv_mask`, and no earlier. `ack_valid` has no effect outside this wait.
- R6: A write to a dirty block owned by another processor asserts `rcl_valid` with `rcl_excl` at 1 (invalidate owner). After `wb_valid` the writer receives `rsp_excl` at 1 and becomes the sole owner.
- R7: A request that arrives while the controller is not idle asserts `nack_valid` in that same cycle, with `nack_dst` set to its source. It changes neither the open transaction nor any directory entry.
- R8: A request from the current owner of a dirty block, or a write to a block with no sharers other than the writer, is answered directly in the third cycle with no recall and no invalidation. `rsp_excl` equals the request's write flag, and a write leaves the writer as sole owner.
- R9: In any cycle at most one of `rcl_valid`, `inv_valid` and `rsp_valid` is high, and each is a single-cycle pulse per transaction. `wb_valid` has no effect outside the recall wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_src | input | 3 | Requesting processor |
| req_addr | input | 4 | Block index |
| ack_valid | input | 1 | One invalidation acknowledgement |
| wb_valid | input | 1 | Owner's recall answer / write-back arrived |
| nack_valid | output | 1 | Refusal of a request that arrived while busy |
| nack_dst | output | 3 | Processor being refused |
| rcl_valid | output | 1 | Recall message to the owner |
| rcl_dst | output | 3 | Owner being recalled |
| rcl_excl | output | 1 | 1 = owner invalidates, 0 = owner downgrades to shared |
| inv_valid | output | 1 | Invalidation message |
| inv_mask | output | 8 | Processors to invalidate |
| rsp_valid | output | 1 | Grant to the requester |
| rsp_dst | output | 3 | Processor receiving the grant |
| rsp_excl | output | 1 | 1 = exclusive grant, 0 = shared grant |
| mem_upd | output | 1 | Write recalled data to home memory |
| mem_addr | output | 4 | Block being written back |

## Verification
One block is driven through a full cycle of states: uncached, then several readers, then a writer with two sharers to invalidate, then a reader that forces a downgrade recall, and finally a writer that forces an exclusive recall. This separates the invalidation path from the two kinds of recall, and it checks the acknowledgement count against the mask population. The owner re-requesting, a writer that is the only sharer and the highest block index test the direct path against wrongly issued coherence traffic. Stray acknowledgements and write-backs are sent in idle and in the wrong wait state, and an intruding request is sent mid-transaction. A following request then shows whether any of these stray inputs leaked into the directory or into the open transaction.

// File: rtl/dir_pkg.sv
`timescale 1ns/1ps
package dir_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_RECALL,
        ST_INVAL,
        ST_REPLY
    } dir_state_e;

    typedef enum logic [1:0] {
        ACT_REPLY,
        ACT_RECALL,
        ACT_INVAL
    } dir_act_e;

endpackage

// File: rtl/dir_store.sv
`timescale 1ns/1ps
module dir_store #(
    parameter int NPROC = 8,
    parameter int NBLK  = 16,
    localparam int AW   = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_addr,
    output logic [NPROC-1:0] rd_pres,
    output logic             rd_dirty,
    input  logic             we,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NPROC-1:0] wr_pres,
    input  logic             wr_dirty
);
    logic [NPROC-1:0] pres_mem  [NBLK];
    logic             dirty_mem [NBLK];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBLK; b++) begin
                pres_mem[b]  <= '0;
                dirty_mem[b] <= 1'b0;
            end
        end else if (we) begin
            pres_mem[wr_addr]  <= wr_pres;
            dirty_mem[wr_addr] <= wr_dirty;
        end
    end

    assign rd_pres  = pres_mem[rd_addr];
    assign rd_dirty = dirty_mem[rd_addr];
endmodule

// File: rtl/dir_decide.sv
`timescale 1ns/1ps
module dir_decide
    import dir_pkg::*;
#(
    parameter int NPROC = 8,
    localparam int IDW  = $clog2(NPROC),
    localparam int CW   = $clog2(NPROC + 1)
) (
    input  logic [NPROC-1:0] pres,
    input  logic             dirty,
    input  logic             is_write,
    input  logic [IDW-1:0]   src,
    output dir_act_e         act,
    output logic [IDW-1:0]   owner,
    output logic [NPROC-1:0] inv_targets,
    output logic [CW-1:0]    inv_count,
    output logic [NPROC-1:0] fin_pres,
    output logic             fin_dirty
);
    logic [NPROC-1:0] src_bit;
    logic [NPROC-1:0] others;

    always_comb begin
        src_bit      = '0;
        src_bit[src] = 1'b1;
        others       = pres & ~src_bit;
    end

    // lowest set presence bit; a dirty entry has exactly one
    always_comb begin
        owner = '0;
        for (int i = NPROC - 1; i >= 0; i--) begin
            if (pres[i]) owner = IDW'(i);
        end
    end

    always_comb begin
        act         = ACT_REPLY;
        inv_targets = '0;
        inv_count   = '0;
        fin_pres    = pres;
        fin_dirty   = dirty;
        if (dirty && !pres[src]) begin
            act = ACT_RECALL;
            if (is_write) begin
                fin_pres  = src_bit;
                fin_dirty = 1'b1;
            end else begin
                fin_pres  = pres | src_bit;
                fin_dirty = 1'b0;
            end
        end else if (dirty) begin
            act = ACT_REPLY;
        end else if (is_write && (others != '0)) begin
            act         = ACT_INVAL;
            inv_targets = others;
            inv_count   = CW'($countones(others));
            fin_pres    = src_bit;
            fin_dirty   = 1'b1;
        end else if (is_write) begin
            fin_pres  = src_bit;
            fin_dirty = 1'b1;
        end else begin
            fin_pres  = pres | src_bit;
            fin_dirty = 1'b0;
        end
    end
endmodule

// File: rtl/ack_tally.sv
`timescale 1ns/1ps
module ack_tally #(
    parameter int NPROC = 8,
    localparam int CW   = $clog2(NPROC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [CW-1:0] remaining;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (dec && (remaining != '0)) begin
            remaining <= remaining - CW'(1);
        end
    end

    assign last = (remaining == CW'(1));
endmodule

// File: rtl/dir_ctrl.sv
`timescale 1ns/1ps
module dir_ctrl
    import dir_pkg::*;
#(
    parameter int NPROC = 8,
    parameter int NBLK  = 16,
    localparam int IDW  = $clog2(NPROC),
    localparam int AW   = $clog2(NBLK),
    localparam int CW   = $clog2(NPROC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDW-1:0]   req_src,
    input  logic [AW-1:0]    req_addr,
    input  logic             ack_valid,
    input  logic             wb_valid,
    output logic             nack_valid,
    output logic [IDW-1:0]   nack_dst,
    output logic             rcl_valid,
    output logic [IDW-1:0]   rcl_dst,
    output logic             rcl_excl,
    output logic             inv_valid,
    output logic [NPROC-1:0] inv_mask,
    output logic             rsp_valid,
    output logic [IDW-1:0]   rsp_dst,
    output logic             rsp_excl,
    output logic             mem_upd,
    output logic [AW-1:0]    mem_addr
);
    dir_state_e state, state_nx;

    logic             cur_write;
    logic [IDW-1:0]   cur_src;
    logic [AW-1:0]    cur_addr;
    logic [NPROC-1:0] fin_pres_q;
    logic             fin_dirty_q;

    logic [NPROC-1:0] ent_pres;
    logic             ent_dirty;
    dir_act_e         act;
    logic [IDW-1:0]   owner;
    logic [NPROC-1:0] inv_targets;
    logic [CW-1:0]    inv_count;
    logic [NPROC-1:0] fin_pres;
    logic             fin_dirty;
    logic             ack_last;

    logic             st_we;
    logic [NPROC-1:0] st_wpres;
    logic             st_wdirty;

    dir_store #(.NPROC(NPROC), .NBLK(NBLK)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (cur_addr),
        .rd_pres  (ent_pres),
        .rd_dirty (ent_dirty),
        .we       (st_we),
        .wr_addr  (cur_addr),
        .wr_pres  (st_wpres),
        .wr_dirty (st_wdirty)
    );

    dir_decide #(.NPROC(NPROC)) u_decide (
        .pres        (ent_pres),
        .dirty       (ent_dirty),
        .is_write    (cur_write),
        .src         (cur_src),
        .act         (act),
        .owner       (owner),
        .inv_targets (inv_targets),
        .inv_count   (inv_count),
        .fin_pres    (fin_pres),
        .fin_dirty   (fin_dirty)
    );

    ack_tally #(.NPROC(NPROC)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state == ST_LOOKUP),
        .load_val (inv_count),
        .dec      ((state == ST_INVAL) && ack_valid),
        .last     (ack_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request and outcome capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_write   <= 1'b0;
            cur_src     <= '0;
            cur_addr    <= '0;
            fin_pres_q  <= '0;
            fin_dirty_q <= 1'b0;
        end else begin
            if ((state == ST_IDLE) && req_valid) begin
                cur_write <= req_write;
                cur_src   <= req_src;
                cur_addr  <= req_addr;
            end
            if (state == ST_LOOKUP) begin
                fin_pres_q  <= fin_pres;
                fin_dirty_q <= fin_dirty;
            end
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_LOOKUP;
            ST_LOOKUP: begin
                unique case (act)
                    ACT_RECALL: state_nx = ST_RECALL;
                    ACT_INVAL:  state_nx = ST_INVAL;
                    default:    state_nx = ST_REPLY;
                endcase
            end
            ST_RECALL: if (wb_valid) state_nx = ST_REPLY;
            ST_INVAL:  if (ack_valid && ack_last) state_nx = ST_REPLY;
            ST_REPLY:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // directory commit on entry to ST_REPLY
    always_comb begin
        st_we     = 1'b0;
        st_wpres  = fin_pres_q;
        st_wdirty = fin_dirty_q;
        unique case (state)
            ST_LOOKUP: begin
                st_we     = (act == ACT_REPLY);
                st_wpres  = fin_pres;
                st_wdirty = fin_dirty;
            end
            ST_RECALL: st_we = wb_valid;
            ST_INVAL:  st_we = ack_valid && ack_last;
            default:   st_we = 1'b0;
        endcase
    end

    // outputs
    always_comb begin
        nack_valid = 1'b0;
        nack_dst   = '0;
        rcl_valid  = 1'b0;
        rcl_dst    = '0;
        rcl_excl   = 1'b0;
        inv_valid  = 1'b0;
        inv_mask   = '0;
        rsp_valid  = 1'b0;
        rsp_dst    = '0;
        rsp_excl   = 1'b0;
        mem_upd    = 1'b0;
        mem_addr   = '0;
        if ((state != ST_IDLE) && req_valid) begin
            nack_valid = 1'b1;
            nack_dst   = req_src;
        end
        unique case (state)
            ST_LOOKUP: begin
                if (act == ACT_RECALL) begin
                    rcl_valid = 1'b1;
                    rcl_dst   = owner;
                    rcl_excl  = cur_write;
                end else if (act == ACT_INVAL) begin
                    inv_valid = 1'b1;
                    inv_mask  = inv_targets;
                end
            end
            ST_RECALL: begin
                if (wb_valid) begin
                    mem_upd  = 1'b1;
                    mem_addr = cur_addr;
                end
            end
            ST_REPLY: begin
                rsp_valid = 1'b1;
                rsp_dst   = cur_src;
                rsp_excl  = cur_write;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dir_ctrl_chk.sv
`timescale 1ns/1ps
module dir_ctrl_chk #(
    parameter int NPROC = 8,
    parameter int NBLK  = 16,
    localparam int IDW  = $clog2(NPROC),
    localparam int AW   = $clog2(NBLK),
    localparam int CW   = $clog2(NPROC + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             ack_valid,
    input logic             wb_valid,
    input logic             nack_valid,
    input logic             rcl_valid,
    input logic             inv_valid,
    input logic [NPROC-1:0] inv_mask,
    input logic             rsp_valid,
    input logic [IDW-1:0]   rsp_dst,
    input logic             mem_upd,
    input logic [AW-1:0]    mem_addr
);
    logic [CW-1:0] pending;

    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else if (inv_valid) pending <= CW'($countones(inv_mask));
        else if (ack_valid && (pending != '0)) pending <= pending - CW'(1);
    end

    // R5
    grant_after_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (pending == '0));

    // R4
    inv_has_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_mask != '0));

    // R7
    nack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nack_valid |-> req_valid);

    // R9
    single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rcl_valid, inv_valid, rsp_valid}));

    // R9
    grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R3
    writeback_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_upd |-> wb_valid);

    // R1
    idle_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_valid |-> (rsp_dst == '0)) and (!mem_upd |-> (mem_addr == '0)));
endmodule

bind dir_ctrl dir_ctrl_chk #(.NPROC(NPROC), .NBLK(NBLK)) u_chk (.*);

// File: tb/tb_dir_ctrl.sv
`timescale 1ns/1ps
module tb_dir_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [2:0] req_src = '0;
    logic [3:0] req_addr = '0;
    logic       ack_valid = 1'b0, wb_valid = 1'b0;
    logic       nack_valid, rcl_valid, rcl_excl, inv_valid, rsp_valid, rsp_excl, mem_upd;
    logic [2:0] nack_dst, rcl_dst, rsp_dst;
    logic [7:0] inv_mask;
    logic [3:0] mem_addr;

    int nvec = 0;
    int nerr = 0;

    logic [7:0] m_pres  [16];
    logic       m_dirty [16];

    always #2.5 clk = ~clk;

    dir_ctrl dut (.*);

    function automatic logic [27:0] mk(
        input logic nk, input logic [2:0] nd,
        input logic rc, input logic [2:0] rd, input logic rx,
        input logic iv, input logic [7:0] im,
        input logic rs, input logic [2:0] sd, input logic sx,
        input logic mu, input logic [3:0] ma);
        return {nk, nd, rc, rd, rx, iv, im, rs, sd, sx, mu, ma};
    endfunction

    task automatic tick(input logic rv, input logic rw, input int rsrc, input int radr,
                        input logic av, input logic wv, input logic [27:0] exp, input string tag);
        logic [27:0] got;
        @(negedge clk);
        req_valid = rv; req_write = rw; req_src = 3'(rsrc); req_addr = 4'(radr);
        ack_valid = av; wb_valid = wv;
        #1;
        got = {nack_valid, nack_dst, rcl_valid, rcl_dst, rcl_excl, inv_valid, inv_mask,
               rsp_valid, rsp_dst, rsp_excl, mem_upd, mem_addr};
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic txn(input logic w, input int s, input int a, input int dly,
                       input int intr, input string tag);
        logic [7:0]  p   = m_pres[a];
        logic        d   = m_dirty[a];
        logic [7:0]  sb  = 8'(1 << s);
        logic [7:0]  oth = p & ~sb;
        int          own = 0;
        logic [27:0] nk  = '0;
        for (int i = 7; i >= 0; i--) if (p[i]) own = i;
        if (intr >= 0) nk = mk(1, 3'(intr), 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        tick(1, w, s, a, 0, 0, '0, tag);
        if (d && !p[s]) begin
            tick(intr >= 0, 1'b0, (intr >= 0) ? intr : 0, 0, 0, 0,
                 mk(0, 0, 1, 3'(own), w, 0, 0, 0, 0, 0, 0, 0) | nk, tag);
            for (int k = 0; k < dly; k++) tick(0, 0, 0, 0, 1, 0, '0, {tag, " stray ack in recall"});
            tick(0, 0, 0, 0, 0, 1, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'(a)), tag);
            m_pres[a]  = w ? sb : (p | sb);
            m_dirty[a] = w;
        end else if (!d && w && (oth != 0)) begin
            tick(intr >= 0, 1'b0, (intr >= 0) ? intr : 0, 0, 0, 0,
                 mk(0, 0, 0, 0, 0, 1, oth, 0, 0, 0, 0, 0) | nk, tag);
            for (int k = 0; k < $countones(oth); k++) begin
                for (int j = 0; j < dly; j++) tick(0, 0, 0, 0, 0, 1, '0, {tag, " stray wb in inval"});
                tick(0, 0, 0, 0, 1, 0, '0, {tag, " ack counted"});
            end
            m_pres[a]  = sb;
            m_dirty[a] = 1'b1;
        end else begin
            tick(intr >= 0, 1'b0, (intr >= 0) ? intr : 0, 0, 0, 0, nk, tag);
            if (!(d && p[s])) begin
                m_pres[a]  = w ? sb : (p | sb);
                m_dirty[a] = w;
            end
        end
        tick(0, 0, 0, 0, 0, 0, mk(0, 0, 0, 0, 0, 0, 0, 1, 3'(s), w, 0, 0), {tag, " reply"});
    endtask

    initial begin
        #(5ns * 100000);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        for (int b = 0; b < 16; b++) begin m_pres[b] = '0; m_dirty[b] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(0, 0, 0, 0, 0, 0, '0, "R1 idle after reset");
        txn(0, 1, 3, 0, -1, "R2 read uncached");
        txn(0, 2, 3, 0, -1, "R2 second reader");
        txn(0, 5, 3, 0, -1, "R2 third reader");
        txn(1, 2, 3, 2, -1, "R4 R5 write to shared");
        txn(0, 6, 3, 3, -1, "R3 read of dirty line");
        txn(1, 7, 3, 1, -1, "R4 R5 write after downgrade");
        txn(1, 0, 3, 2, 1, "R6 R7 write to dirty with intruder");
        txn(1, 0, 3, 0, -1, "R8 owner rewrites");
        txn(1, 4, 9, 0, -1, "R8 write uncached");
        txn(0, 4, 9, 0, 6, "R8 R7 owner reads");
        txn(0, 3, 12, 0, -1, "R2 sole reader");
        txn(1, 3, 12, 0, -1, "R8 write by sole sharer");
        tick(0, 0, 0, 0, 1, 0, '0, "R5 stray ack idle");
        tick(0, 0, 0, 0, 0, 1, '0, "R9 stray wb idle");
        txn(0, 5, 12, 1, -1, "R3 R9 recall after stray inputs");
        txn(0, 7, 15, 0, -1, "R2 top block");
        txn(1, 1, 9, 0, -1, "R6 write to dirty after stray");
        tick(0, 0, 0, 0, 0, 0, '0, "R1 quiet end");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule